// File: doc/BRIEF.md
# Byte-to-Word Deserializer with COM Ordering

This block sits on the receive side of a serial link, after symbol decoding. It takes one byte per fast clock cycle, each byte tagged with a control/data flag, and packs pairs of bytes into 16-bit words for logic that runs at half the byte rate. The half-rate clock is represented by an enable, `hr_en`, which the surrounding logic pulses on every second fast cycle. All outputs change only on enabled cycles, so each output value lasts one half-rate period.

The block also fixes byte ordering. Ordered sets begin with the COM control symbol, and downstream parsers expect that symbol in the low byte of a word. After reset the block discards input until it sees the first COM, then pairs from there. If a COM later arrives where it would fill the upper byte, the block drops the pending low byte, starts a new pair with the COM as its low byte, and pulses `slip` for one fast cycle. If input valid drops in the middle of a pair, the half-filled pair waits for the next valid byte. A partial word is never issued.

Top module: `bdes_byte_to_word`

## Requirements
- R1: While reset is held, `word_vld`, `aligned` and `slip` are 0. In the first cycle after reset they are still 0.
- R2: Until the first COM has been received after reset, every input byte is discarded. No word is issued and `aligned` stays 0.
- R3: `aligned` rises in the same half-rate period as the first issued word. The low byte of that word is the COM and mask bit 0 is 1. `aligned` then stays 1 until reset.
- R4: The earlier byte of a pair is placed in `word_data[7:0]` and the later byte in `word_data[15:8]`. The K flag of each byte goes to `word_k[0]` and `word_k[1]` respectively.
- R5: A byte is a COM only when its value is 0xBC and its K flag is 1. 0xBC with K=0, and any other value with K=1, are ordinary bytes.
- R6: A COM that arrives while a low byte is pending causes the following. The pending byte is dropped. The COM becomes the new low byte. `slip` is 1 in the fast cycle right after that byte is taken. `slip` is 1 only in such a cycle.
- R7: A valid gap inside a pair holds the pending byte until the next valid byte arrives. A lone pending byte never produces a word. A completed pair is never lost before it is issued.
- R8: `word_vld`, `word_data`, `word_k` and `aligned` change only on clock edges where `hr_en` is 1. `hr_en` must be 1 on every second cycle.
- R9: No issued word carries a COM (0xBC with K=1) in its upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (byte-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| hr_en | input | 1 | Half-rate enable, 1 on every second cycle |
| in_vld | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_k | input | 1 | Input byte is a control symbol |
| word_vld | output | 1 | Output word valid for this half-rate period |
| word_data | output | 16 | Output word, earlier byte in bits 7:0 |
| word_k | output | 2 | Control flag per output byte |
| aligned | output | 1 | Word alignment to COM has been reached |
| slip | output | 1 | One-cycle pulse when a pending low byte was dropped |

## Verification
The assertions check the following on every cycle:
- outputs hold between enabled edges;
- no COM ever appears in an upper byte;
- no word is issued before alignment;
- a slip always follows a COM input;
- a completed pair never meets a still-occupied stage outside an enabled edge;
- the first word after alignment opens with a COM.

Only the bench scenarios can show the following:
- the exact lane order of bytes and K flags;
- that bytes seen before the first COM (including 0xBC without K) are truly discarded;
- that a pending byte survives long valid gaps;
- that a trailing odd byte never turns into a word;
- that the number of slips matches the stream.

// File: rtl/bdes_pkg.sv
`timescale 1ns/1ps
package bdes_pkg;

  // Pairing state: hunting for the first COM, or filling byte lanes.
  typedef enum logic {
    PS_HUNT = 1'b0,
    PS_FILL = 1'b1
  } pair_state_e;

endpackage

// File: rtl/bdes_com_detect.sv
`timescale 1ns/1ps
module bdes_com_detect #(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] COM_CODE = BYTE_W'(8'hBC)
) (
  input  logic              in_vld,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_k,
  output logic              is_com
);

  // A COM needs both the control flag and the exact code value.
  always_comb begin
    is_com = in_vld && in_k && (in_data == COM_CODE);
  end

endmodule

// File: rtl/bdes_pair_fsm.sv
`timescale 1ns/1ps
module bdes_pair_fsm
  import bdes_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic [BYTE_W-1:0]        in_data,
  input  logic                     in_k,
  input  logic                     is_com,
  output logic                     pair_done,
  output logic [BYTE_W*LANES-1:0]  pair_data,
  output logic [LANES-1:0]         pair_k,
  output logic                     slip
);

  localparam int              IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  pair_state_e             state;
  logic [IDX_W-1:0]        idx;
  logic [BYTE_W-1:0]       lane_d [LANES];
  logic                    lane_k [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PS_HUNT;
      idx       <= '0;
      pair_done <= 1'b0;
      slip      <= 1'b0;
      for (int i = 0; i < LANES; i++) begin
        lane_d[i] <= '0;
        lane_k[i] <= 1'b0;
      end
    end else begin
      pair_done <= 1'b0;
      slip      <= 1'b0;
      if (in_vld) begin
        case (state)
          PS_HUNT: begin
            // Everything before the first COM is thrown away.
            if (is_com) begin
              lane_d[0] <= in_data;
              lane_k[0] <= in_k;
              idx       <= ONE;
              state     <= PS_FILL;
            end
          end
          default: begin
            if (is_com && (idx != '0)) begin
              // COM would land above lane 0: drop pending bytes, restart.
              lane_d[0] <= in_data;
              lane_k[0] <= in_k;
              idx       <= ONE;
              slip      <= 1'b1;
            end else begin
              lane_d[idx] <= in_data;
              lane_k[idx] <= in_k;
              if (idx == LAST) begin
                idx       <= '0;
                pair_done <= 1'b1;
              end else begin
                idx <= idx + ONE;
              end
            end
          end
        endcase
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_flat
    assign pair_data[g*BYTE_W +: BYTE_W] = lane_d[g];
    assign pair_k[g]                     = lane_k[g];
  end

endmodule

// File: rtl/bdes_word_stage.sv
`timescale 1ns/1ps
module bdes_word_stage #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hr_en,
  input  logic                     pair_done,
  input  logic [BYTE_W*LANES-1:0]  pair_data,
  input  logic [LANES-1:0]         pair_k,
  output logic                     stg_vld,
  output logic                     word_vld,
  output logic [BYTE_W*LANES-1:0]  word_data,
  output logic [LANES-1:0]         word_k,
  output logic                     aligned
);

  localparam int WORD_W = BYTE_W * LANES;

  logic [WORD_W-1:0] stg_d;
  logic [LANES-1:0]  stg_k;

  // One-entry stage in the fast domain; the half-rate side reads it
  // only on enabled edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld   <= 1'b0;
      stg_d     <= '0;
      stg_k     <= '0;
      word_vld  <= 1'b0;
      word_data <= '0;
      word_k    <= '0;
      aligned   <= 1'b0;
    end else begin
      if (hr_en) begin
        word_vld  <= stg_vld;
        word_data <= stg_vld ? stg_d : '0;
        word_k    <= stg_vld ? stg_k : '0;
        aligned   <= aligned | stg_vld;
      end
      if (pair_done) begin
        stg_vld <= 1'b1;
        stg_d   <= pair_data;
        stg_k   <= pair_k;
      end else if (hr_en) begin
        stg_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bdes_byte_to_word.sv
`timescale 1ns/1ps
module bdes_byte_to_word #(
  parameter int                BYTE_W   = 8,
  parameter int                LANES    = 2,
  parameter logic [BYTE_W-1:0] COM_CODE = BYTE_W'(8'hBC)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     hr_en,
  input  logic                     in_vld,
  input  logic [BYTE_W-1:0]        in_data,
  input  logic                     in_k,
  output logic                     word_vld,
  output logic [BYTE_W*LANES-1:0]  word_data,
  output logic [LANES-1:0]         word_k,
  output logic                     aligned,
  output logic                     slip
);

  localparam int WORD_W = BYTE_W * LANES;

  logic              is_com;
  logic              pair_done;
  logic [WORD_W-1:0] pair_data;
  logic [LANES-1:0]  pair_k;
  logic              stg_vld;

  bdes_com_detect #(
    .BYTE_W   (BYTE_W),
    .COM_CODE (COM_CODE)
  ) u_com (
    .in_vld  (in_vld),
    .in_data (in_data),
    .in_k    (in_k),
    .is_com  (is_com)
  );

  bdes_pair_fsm #(
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
  ) u_pair (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_data   (in_data),
    .in_k      (in_k),
    .is_com    (is_com),
    .pair_done (pair_done),
    .pair_data (pair_data),
    .pair_k    (pair_k),
    .slip      (slip)
  );

  bdes_word_stage #(
    .BYTE_W (BYTE_W),
    .LANES  (LANES)
  ) u_stage (
    .clk       (clk),
    .rst       (rst),
    .hr_en     (hr_en),
    .pair_done (pair_done),
    .pair_data (pair_data),
    .pair_k    (pair_k),
    .stg_vld   (stg_vld),
    .word_vld  (word_vld),
    .word_data (word_data),
    .word_k    (word_k),
    .aligned   (aligned)
  );

endmodule

// File: rtl/bdes_checker.sv
`timescale 1ns/1ps
module bdes_checker #(
  parameter int                BYTE_W   = 8,
  parameter int                LANES    = 2,
  parameter logic [BYTE_W-1:0] COM_CODE = BYTE_W'(8'hBC)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     hr_en,
  input logic                     in_vld,
  input logic [BYTE_W-1:0]        in_data,
  input logic                     in_k,
  input logic                     word_vld,
  input logic [BYTE_W*LANES-1:0]  word_data,
  input logic [LANES-1:0]         word_k,
  input logic                     aligned,
  input logic                     slip,
  input logic                     pair_done,
  input logic                     stg_vld
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!word_vld && !aligned && !slip));

  // R2
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !aligned |-> !word_vld);

  // R3
  first_word_com_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> (word_vld && word_k[0] && (word_data[BYTE_W-1:0] == COM_CODE)));

  // R6
  slip_cause_chk: assert property (@(posedge clk) disable iff (rst)
    slip |-> $past(in_vld && in_k && (in_data == COM_CODE)));

  // R7
  stage_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_done && stg_vld) |-> hr_en);

  // R8
  half_rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(hr_en) |-> ($stable(word_vld) && $stable(word_data) &&
                       $stable(word_k) && $stable(aligned)));

  for (genvar g = 1; g < LANES; g++) begin : g_upper
    // R9
    upper_no_com_chk: assert property (@(posedge clk) disable iff (rst)
      word_vld |-> !(word_k[g] && (word_data[g*BYTE_W +: BYTE_W] == COM_CODE)));
  end

endmodule

bind bdes_byte_to_word bdes_checker #(
  .BYTE_W   (BYTE_W),
  .LANES    (LANES),
  .COM_CODE (COM_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .hr_en     (hr_en),
  .in_vld    (in_vld),
  .in_data   (in_data),
  .in_k      (in_k),
  .word_vld  (word_vld),
  .word_data (word_data),
  .word_k    (word_k),
  .aligned   (aligned),
  .slip      (slip),
  .pair_done (pair_done),
  .stg_vld   (stg_vld)
);

// File: tb/sim_bdes_byte_to_word.sv
`timescale 1ns/1ps
module sim_bdes_byte_to_word;

  localparam logic [7:0] COM = 8'hBC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hr_en = 1'b0;
  logic        in_vld = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_k = 1'b0;
  logic        word_vld;
  logic [15:0] word_data;
  logic [1:0]  word_k;
  logic        aligned;
  logic        slip;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bdes_byte_to_word u0 (
    .clk(clk), .rst(rst), .hr_en(hr_en), .in_vld(in_vld), .in_data(in_data),
    .in_k(in_k), .word_vld(word_vld), .word_data(word_data), .word_k(word_k),
    .aligned(aligned), .slip(slip)
  );

  // Reference state, derived from the requirements.
  bit          m_hunt = 1;
  bit          m_half = 0;
  logic [7:0]  m_lo_d = '0;
  logic        m_lo_k = 1'b0;
  logic [17:0] exp_q [$];
  bit          exp_al = 0;
  int          slips_seen = 0;
  int          slips_exp = 0;
  logic [19:0] last_out = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_byte(input logic k, input logic [7:0] d, output bit slp);
    bit com;
    com = k && (d == COM);   // R5: only 0xBC with K=1
    slp = 0;
    if (m_hunt) begin
      if (com) begin m_hunt = 0; m_lo_d = d; m_lo_k = k; m_half = 1; end
    end else if (!m_half) begin
      m_lo_d = d; m_lo_k = k; m_half = 1;
    end else if (com) begin
      m_lo_d = d; m_lo_k = k; slp = 1;   // R6 slip
    end else begin
      exp_q.push_back({k, m_lo_k, d, m_lo_d});  // R4 lane order
      m_half = 0;
    end
  endtask

  task automatic model_reset();
    m_hunt = 1; m_half = 0; exp_al = 0;
    exp_q.delete();
  endtask

  task automatic step(input logic v, input logic k, input logic [7:0] d, input bit chk);
    bit en_now, es;
    logic [17:0] e;
    in_vld = v; in_k = k; in_data = d;
    en_now = hr_en;
    es = 0;
    if (v && !rst) model_byte(k, d, es);
    @(posedge clk); #1;
    if (chk) begin
      // R6: slip one cycle after the causing byte
      check(slip == es, "R6 slip pulse", 32'(slip), 32'(es));
      if (slip) slips_seen++;
      if (es) slips_exp++;
      if (en_now) begin
        if (word_vld) begin
          if (exp_q.size() == 0) begin
            check(0, "R2/R7 unexpected word", 32'({word_k, word_data}), 32'h0);
          end else begin
            e = exp_q.pop_front();
            if (!exp_al)
              check(word_k[0] && word_data[7:0] == COM, "R3 first word COM low",
                    32'({word_k, word_data}), 32'({2'b01, 8'h00, COM}));
            check({word_k, word_data} == e, "R4 word content",
                  32'({word_k, word_data}), 32'(e));
            exp_al = 1;
          end
        end
        check(aligned == exp_al, "R2/R3 aligned", 32'(aligned), 32'(exp_al));
      end else begin
        check({word_vld, word_k, word_data, aligned} == last_out, "R8 hold off-enable",
              32'({word_vld, word_k, word_data, aligned}), 32'(last_out));
      end
    end
    last_out = {word_vld, word_k, word_data, aligned};
    hr_en = ~hr_en;
  endtask

  task automatic do_reset();
    rst = 1;
    for (int i = 0; i < 6; i++) step(0, 0, 8'h00, 0);
    model_reset();
    rst = 0;
    step(0, 0, 8'h00, 0);
    // R1 reset state
    check(!word_vld && !aligned && !slip, "R1 reset state",
          32'({word_vld, aligned, slip}), 32'h0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R2, R5: pre-alignment junk, including 0xBC without K and K codes
    step(1, 0, COM, 1);
    step(1, 1, 8'h1C, 1);
    step(1, 0, 8'h5A, 1);
    step(0, 0, 8'h00, 1);
    step(1, 1, 8'hFC, 1);
    step(1, 0, COM, 1);
    drain(4);
    check(!aligned && !word_vld, "R2 no word before COM", 32'({aligned, word_vld}), 32'h0);

    // R3, R4: first COM then directed data
    step(1, 1, COM, 1);
    step(1, 0, 8'h11, 1);
    step(1, 1, 8'h22, 1);
    step(1, 0, 8'h33, 1);
    drain(4);
    check(aligned == 1'b1, "R3 aligned after first COM", 32'(aligned), 32'h1);

    // R6: COM on the upper position after a pending low byte
    step(1, 0, 8'h44, 1);
    step(1, 1, COM, 1);
    step(1, 0, 8'h55, 1);
    // R6: back-to-back COMs
    step(1, 1, COM, 1);
    step(1, 1, COM, 1);
    step(1, 1, COM, 1);
    step(1, 0, 8'h66, 1);
    drain(4);

    // R7: long gap inside a pair
    step(1, 0, 8'h77, 1);
    drain(9);
    step(1, 1, 8'h88, 1);
    drain(4);

    // Random stream with random gaps and COMs
    for (int i = 0; i < 4000; i++) begin
      logic v, k;
      logic [7:0] d;
      v = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) begin
        k = 1; d = COM;
      end else begin
        k = (($urandom % 8) == 0);
        d = 8'($urandom);
      end
      step(v, k, d, 1);
    end
    drain(6);

    // R7: a trailing odd byte never becomes a word
    if (!m_half) step(1, 0, 8'h99, 1);
    drain(12);
    check(exp_q.size() == 0, "R7 no partial or lost word", 32'(exp_q.size()), 32'h0);
    check(slips_seen == slips_exp, "R6 slip count", 32'(slips_seen), 32'(slips_exp));

    // R1, R2: reset mid-run drops alignment
    do_reset();
    for (int i = 0; i < 20; i++) step(1, 0, 8'(i * 7), 1);
    check(!aligned && !word_vld, "R2 hunt again after reset", 32'({aligned, word_vld}), 32'h0);
    step(1, 1, COM, 1);
    step(1, 0, 8'hA5, 1);
    drain(6);
    check(aligned == 1'b1 && exp_q.size() == 0, "R3 realign after reset",
          32'({aligned, 8'(exp_q.size())}), 32'h100);

    finished = 1;
    finish_run();
  end

endmodule